// File: doc/BRIEF.md
# Loopback and Lock-Gated Output Router

This block sits between the local serial-port pins of a two-ended link modem and the link's transmit and receive paths. It carries one main data channel and three low-rate side channels (request-to-send, terminal-ready and ring indicate). A registered three-bit diagnostic code picks one of three behaviours. In normal full-duplex operation, local inputs go out over the link and received channels drive the local outputs. In local loopback, the local inputs are returned straight to the local outputs. In remote loopback, a request is raised towards the far end so that it returns the traffic.

When the far end sends a loopback request, this end echoes what it receives back onto the link and also presents it on its own outputs. While the link is not locked, the outputs are held at safe idle levels and the active-low carrier-detect output stays high. Local loopback is exempt from this forcing. Framing and line coding are handled elsewhere.

Top module: `loopback_router`

## Requirements
- R1: The mode code is sampled on each rising clock edge and takes effect only after that edge. Reset loads code 111 (full duplex).
- R2: In full duplex (code 111), with lock high and no far-end request, the outputs follow the received channels and the link transmit carries the local channels. Received bit 0 maps to rxd_o, bit 1 to cts_o, bit 2 to dsr_o and bit 3 to rio_o. The same bit order (0 data, 1 RTS, 2 DTR, 3 ring) applies to loc_ch_i, lnk_rx_i and lnk_tx_o.
- R3: In local loopback (code 101), local bit 0 drives rxd_o, bit 1 drives cts_o, bit 2 drives dsr_o and bit 3 drives rio_o. lnk_tx_o still carries loc_ch_i.
- R4: In local loopback, received channel data and the lock state have no effect on rxd_o, cts_o, dsr_o or rio_o.
- R5: Code 110 raises rlb_req_tx_o, except while a far-end request is being answered. Every other code keeps it low.
- R6: When not in local loopback, with lock high and rlb_req_rx_i high, lnk_tx_o equals lnk_rx_i and the outputs show the received channels.
- R7: Outside local loopback, while lock is low: rxd_o is 0, cts_o and dsr_o are 1, rio_o is 0, and no far-end request is answered. cd_n_o is the inverse of lock_i in every mode.
- R8: Local loopback takes priority over a far-end request. In code 101, lnk_tx_o stays loc_ch_i even when lock and rlb_req_rx_i are high.
- R9: Codes 000, 001, 010, 011 and 100 behave exactly like code 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Diagnostic mode code |
| lock_i | input | 1 | Link locked status |
| loc_ch_i | input | 4 | Local channels {ring, DTR, RTS, data} |
| lnk_rx_i | input | 4 | Channels received from the link, same order |
| rlb_req_rx_i | input | 1 | Loopback request received from the far end |
| rxd_o | output | 1 | Main data output |
| cts_o | output | 1 | Clear-to-send output |
| dsr_o | output | 1 | Data-set-ready output |
| rio_o | output | 1 | Ring indicate output |
| cd_n_o | output | 1 | Carrier detect, active low |
| lnk_tx_o | output | 4 | Channels sent to the link |
| rlb_req_tx_o | output | 1 | Loopback request sent to the far end |

## Verification
The stimulus covers several cases:
- Random channel data with each mode code, under both lock states, with and without a far-end request. These separate the source of each output (local, received or forced) and the source of the link transmit.
- Mode changes placed between edges. These show that the code acts one edge late.
- Local loopback combined with an unlocked link, or with a far-end request. These expose a wrong priority.
- Code 110 combined with a far-end request. This shows the own request being withheld.

// File: rtl/loopback_router.sv
module loopback_router (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       lock_i,
  input  logic [3:0] loc_ch_i,
  input  logic [3:0] lnk_rx_i,
  input  logic       rlb_req_rx_i,
  output logic       rxd_o,
  output logic       cts_o,
  output logic       dsr_o,
  output logic       rio_o,
  output logic       cd_n_o,
  output logic [3:0] lnk_tx_o,
  output logic       rlb_req_tx_o
);
  localparam logic [2:0] MODE_LOCAL  = 3'b101;
  localparam logic [2:0] MODE_REMOTE = 3'b110;
  localparam logic [2:0] MODE_RESET  = 3'b111;
  localparam logic [3:0] IDLE_OUT    = 4'b0110;

  logic [2:0] mode_q;
  logic       loc_lb;
  logic       answering;
  logic [3:0] outs;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_q <= MODE_RESET;
    else        mode_q <= mode_i;

  assign loc_lb    = (mode_q == MODE_LOCAL);
  assign answering = !loc_lb && lock_i && rlb_req_rx_i;

  always_comb begin
    if (loc_lb)       outs = loc_ch_i;
    else if (!lock_i) outs = IDLE_OUT;
    else              outs = lnk_rx_i;
  end

  assign {rio_o, dsr_o, cts_o, rxd_o} = outs;
  assign lnk_tx_o     = answering ? lnk_rx_i : loc_ch_i;
  assign rlb_req_tx_o = (mode_q == MODE_REMOTE) && !answering;
  assign cd_n_o       = !lock_i;
endmodule

// File: rtl/loopback_router_chk.sv
module loopback_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic       lock_i,
  input logic [3:0] loc_ch_i,
  input logic [3:0] lnk_rx_i,
  input logic       rlb_req_rx_i,
  input logic       rxd_o,
  input logic       cts_o,
  input logic       dsr_o,
  input logic       rio_o,
  input logic       cd_n_o,
  input logic [3:0] lnk_tx_o,
  input logic       rlb_req_tx_o
);
  p_loop_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i) == 3'b101) |-> ({rio_o, dsr_o, cts_o, rxd_o} == loc_ch_i));

  p_loop_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i) == 3'b101) |-> (lnk_tx_o == loc_ch_i));

  p_unlock_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i) != 3'b101 && !lock_i) |->
      ({rio_o, dsr_o, cts_o, rxd_o} == 4'b0110 && cd_n_o && lnk_tx_o == loc_ch_i));

  p_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i) != 3'b101 && lock_i && rlb_req_rx_i) |->
      (lnk_tx_o == lnk_rx_i && {rio_o, dsr_o, cts_o, rxd_o} == lnk_rx_i));

  p_req_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && rlb_req_rx_i) |-> !rlb_req_tx_o);

  p_req_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rlb_req_tx_o && $past(rst_n)) |-> ($past(mode_i) == 3'b110));
endmodule

bind loopback_router loopback_router_chk u_chk (.*);

// File: tb/sim_loopback_router.sv
module sim_loopback_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_i = 3'b111;
  logic       lock_i = 1'b0;
  logic [3:0] loc_ch_i = '0;
  logic [3:0] lnk_rx_i = '0;
  logic       rlb_req_rx_i = 1'b0;
  logic       rxd_o, cts_o, dsr_o, rio_o, cd_n_o, rlb_req_tx_o;
  logic [3:0] lnk_tx_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mode_ref = 7;

  always #2 clk = ~clk;

  loopback_router u0 (.*);

  always @(posedge clk or negedge rst_n)
    if (!rst_n) mode_ref <= 7;
    else        mode_ref <= int'(mode_i);

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    bit loc, ans;
    int eo, et, eq;
    string tag;
    loc = (mode_ref == 5);
    ans = !loc && lock_i && rlb_req_rx_i;
    eo  = loc ? int'(loc_ch_i) : (!lock_i ? 6 : int'(lnk_rx_i));
    et  = ans ? int'(lnk_rx_i) : int'(loc_ch_i);
    eq  = (mode_ref == 6 && !ans) ? 1 : 0;
    if (rst_n && mode_ref != int'(mode_i)) tag = "R1";
    else if (loc && lock_i && rlb_req_rx_i) tag = "R8";
    else if (loc && !lock_i) tag = "R4";
    else if (loc) tag = "R3";
    else if (!lock_i) tag = "R7";
    else if (ans) tag = "R6";
    else if (mode_ref == 6) tag = "R5";
    else if (mode_ref != 7) tag = "R9";
    else tag = "R2";
    cmp(tag, "outs", int'({rio_o, dsr_o, cts_o, rxd_o}), eo);
    cmp(tag, "lnk_tx", int'(lnk_tx_o), et);
    cmp(tag, "req_tx", int'(rlb_req_tx_o), eq);
    cmp("R7", "cd_n", int'(cd_n_o), lock_i ? 0 : 1);
  endtask

  always @(negedge clk) if (!done) check_all();

  task automatic drive(int m, bit lk, int lc, int rx, bit rq);
    @(posedge clk); #1;
    mode_i = 3'(m); lock_i = lk; loc_ch_i = 4'(lc); lnk_rx_i = 4'(rx); rlb_req_rx_i = rq;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    drive(7, 1, 4'h3, 4'hA, 0);
    drive(7, 1, 4'h5, 4'h9, 0);
    drive(5, 0, 4'hF, 4'h0, 0);
    drive(5, 0, 4'h1, 4'hE, 0);
    drive(5, 1, 4'h6, 4'h9, 1);
    drive(6, 1, 4'h2, 4'hC, 0);
    drive(6, 1, 4'h2, 4'hC, 1);
    drive(6, 0, 4'h4, 4'h3, 1);
    drive(7, 1, 4'h8, 4'h7, 1);
    drive(0, 1, 4'h1, 4'h2, 0);
    drive(3, 0, 4'h1, 4'h2, 0);
    drive(4, 1, 4'hB, 4'hD, 0);
    for (int i = 0; i < 3000; i++)
      drive($urandom_range(0, 7), 1'($urandom), $urandom_range(0, 15),
            $urandom_range(0, 15), 1'($urandom));
    @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    done = 1;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule